// File: doc/BRIEF.md
# Clock Synthesizer Divider and Lock Sequencer

This block is the digital control side of a frequency synthesizer that multiplies a slow reference clock. A single 16-bit control register holds three configuration fields. The feedback exponent `W` and the feedback multiplier `Y` program a divider in the loop's feedback path. Its output `fb_clk` goes to an external phase comparator. The output speed select `X` programs a small divider behind the oscillator. That divider produces the system clock and stays outside the loop.

A programmable relock timer stands in for the analog loop. The timer runs on the reference clock. A write that alters `W` or `Y` drops the lock flag and restarts the timer. A write that alters only `X` changes the system clock rate and leaves the lock untouched. After power-up, a reset-hold output keeps the rest of the chip in reset until the first lock is reached.

The register interface is a plain write strobe with a data word, plus a read word that is always visible. The block carries no streaming data, so every pin is a plain control or status signal with no valid/ready handshake. With the loop locked, the system clock is fsys = 4·fref·(Y+1)·2^(2W+X). The register resets to 0x3F00, which gives about 8.388 MHz from a 32.768 kHz reference.

Top module: `pll_divider_ctl`

## Requirements
- R1: Register layout: W is bit 15, X is bit 14 and Y[5:0] is bits 13:8. The read-only lock flag is bit 3. All other bits always read as zero.
- R2: Reset state: the register reads 0x3F00, the lock flag is 0 and `rst_hold` is 1.
- R3: `fb_clk` has a period of 16·(Y+1)·4^W `vco_clk` cycles, with equal high and low halves.
- R4: `sys_clk` has a period of 4 `vco_clk` cycles when X=0 and 2 `vco_clk` cycles when X=1.
- R5: A write whose W or Y differs from the stored value clears the lock flag at that reference edge. The flag then sets exactly RELOCK_CYCLES reference edges later if no further W/Y change occurs. Once set, the flag stays set until such a write.
- R6: A write that changes only X, or changes nothing in W and Y, leaves the lock flag as it was.
- R7: Writing a 1 to bit 3 does not set the lock flag.
- R8: `rst_hold` stays 1 from reset until the first time the lock flag sets. It falls on that same edge and stays 0 until the next reset.
- R9: A W/Y-changing write made while the lock flag is low restarts the relock period from that write.
- R10: A change of X is applied only at the end of a full output phase. Every high or low pulse of `sys_clk` therefore lasts exactly 1 or 2 `vco_clk` cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Reference clock; clocks the register and the relock timer |
| vco_clk | input | 1 | Oscillator clock; clocks both dividers |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe, sampled on `ref_clk` |
| wr_data | input | 16 | Register write data |
| rd_data | output | 16 | Current register contents including the lock flag |
| sys_clk | output | 1 | System clock, `vco_clk` divided by 4 or 2 |
| fb_clk | output | 1 | Feedback clock to the phase comparator |
| slock | output | 1 | Lock flag, same as bit 3 of `rd_data` |
| rst_hold | output | 1 | High while the chip must be held in reset |

## Verification
The bound assertions watch the lock rules on every reference edge:
- a W/Y-changing write always drops the lock;
- any other write, or no write at all, keeps an existing lock;
- the reset-hold falls only together with a lock and never returns;
- the unused register bits stay zero.

Other behaviours can only be shown by the bench's scenarios. These are the exact relock delay and its restart by a second write, the divide ratios measured in time over a sweep of W, X and Y, and the pulse widths of `sys_clk` across repeated X switches.

// File: rtl/pll_ctl_pkg.sv
package pll_ctl_pkg;
  localparam int REG_W    = 16;
  localparam int Y_W      = 6;
  localparam int W_POS    = 15;
  localparam int X_POS    = 14;
  localparam int Y_LO     = 8;
  localparam int LOCK_POS = 3;
  // half period of the feedback clock reaches 8*64*4 = 2048 oscillator cycles
  localparam int FB_W     = 12;

  typedef struct packed {
    logic           w;
    logic           x;
    logic [Y_W-1:0] y;
  } syn_cfg_t;

  localparam syn_cfg_t CFG_RESET = '{w: 1'b0, x: 1'b0, y: {Y_W{1'b1}}};

  function automatic syn_cfg_t cfg_from_word(input logic [REG_W-1:0] d);
    syn_cfg_t c;
    c.w = d[W_POS];
    c.x = d[X_POS];
    c.y = d[Y_LO +: Y_W];
    return c;
  endfunction

  function automatic logic [REG_W-1:0] word_from_cfg(input syn_cfg_t c, input logic lock);
    logic [REG_W-1:0] d;
    d                = '0;
    d[W_POS]         = c.w;
    d[X_POS]         = c.x;
    d[Y_LO +: Y_W]   = c.y;
    d[LOCK_POS]      = lock;
    return d;
  endfunction
endpackage

// File: rtl/synth_ctl_reg.sv
module synth_ctl_reg
  import pll_ctl_pkg::*;
#(
  parameter int RELOCK_CYCLES = 4096
) (
  input  logic             ref_clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output syn_cfg_t         cfg_o,
  output logic             lock_o,
  output logic             hold_o
);
  localparam int CNT_W = (RELOCK_CYCLES > 2) ? $clog2(RELOCK_CYCLES) : 1;
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(RELOCK_CYCLES - 1);

  syn_cfg_t         cfg_q;
  syn_cfg_t         cfg_new;
  logic [CNT_W-1:0] cnt_q;
  logic             lock_q;
  logic             hold_q;
  logic             loop_change;

  assign cfg_new     = cfg_from_word(wr_data);
  assign loop_change = wr_en && ({cfg_new.w, cfg_new.y} != {cfg_q.w, cfg_q.y});

  always_ff @(posedge ref_clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= CFG_RESET;
    end else if (wr_en) begin
      cfg_q <= cfg_new;
    end
  end

  always_ff @(posedge ref_clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= CNT_LOAD;
      lock_q <= 1'b0;
      hold_q <= 1'b1;
    end else if (loop_change) begin
      cnt_q  <= CNT_LOAD;
      lock_q <= 1'b0;
    end else if (!lock_q) begin
      if (cnt_q == '0) begin
        lock_q <= 1'b1;
        hold_q <= 1'b0;
      end else begin
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end

  assign cfg_o  = cfg_q;
  assign lock_o = lock_q;
  assign hold_o = hold_q;
endmodule

// File: rtl/cfg_sync.sv
module cfg_sync #(
  parameter int             WIDTH     = 8,
  parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] meta_q;
  logic [WIDTH-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= RESET_VAL;
      sync_q <= RESET_VAL;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;
endmodule

// File: rtl/fb_divider.sv
module fb_divider
  import pll_ctl_pkg::*;
(
  input  logic           vco_clk,
  input  logic           rst_n,
  input  logic           w_i,
  input  logic [Y_W-1:0] y_i,
  output logic           fb_clk_o
);
  logic [FB_W-1:0] half_len;
  logic [FB_W-1:0] cnt_q;
  logic            fb_q;

  // half period = 8*(Y+1)*4^W oscillator cycles
  always_comb begin
    half_len = FB_W'({1'b0, y_i} + 7'd1);
    half_len = w_i ? (half_len << 5) : (half_len << 3);
  end

  // the new ratio is picked up only at a half-period boundary
  always_ff @(posedge vco_clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      fb_q  <= 1'b0;
    end else if (cnt_q == '0) begin
      cnt_q <= half_len - FB_W'(1);
      fb_q  <= ~fb_q;
    end else begin
      cnt_q <= cnt_q - FB_W'(1);
    end
  end

  assign fb_clk_o = fb_q;
endmodule

// File: rtl/out_divider.sv
module out_divider (
  input  logic vco_clk,
  input  logic rst_n,
  input  logic x_i,
  output logic sys_clk_o
);
  logic [1:0] ph_q;
  logic [1:0] ph_next;
  logic       x_q;
  logic       x_next;
  logic       sys_q;

  assign ph_next = ph_q + 2'd1;
  // the select moves only as the phase wraps, where both taps fall together
  assign x_next  = (ph_q == 2'd3) ? x_i : x_q;

  always_ff @(posedge vco_clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q  <= 2'd0;
      x_q   <= 1'b0;
      sys_q <= 1'b0;
    end else begin
      ph_q  <= ph_next;
      x_q   <= x_next;
      sys_q <= x_next ? ph_next[0] : ph_next[1];
    end
  end

  assign sys_clk_o = sys_q;
endmodule

// File: rtl/pll_divider_ctl.sv
module pll_divider_ctl
  import pll_ctl_pkg::*;
#(
  parameter int RELOCK_CYCLES = 4096
) (
  input  logic        ref_clk,
  input  logic        vco_clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [15:0] wr_data,
  output logic [15:0] rd_data,
  output logic        sys_clk,
  output logic        fb_clk,
  output logic        slock,
  output logic        rst_hold
);
  localparam int CFG_BITS = $bits(syn_cfg_t);

  syn_cfg_t cfg_ref;
  syn_cfg_t cfg_vco;
  logic     lock_w;
  logic     hold_w;

  synth_ctl_reg #(.RELOCK_CYCLES(RELOCK_CYCLES)) u_reg (
    .ref_clk (ref_clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .cfg_o   (cfg_ref),
    .lock_o  (lock_w),
    .hold_o  (hold_w)
  );

  cfg_sync #(.WIDTH(CFG_BITS), .RESET_VAL(CFG_RESET)) u_sync (
    .clk   (vco_clk),
    .rst_n (rst_n),
    .d_i   (cfg_ref),
    .q_o   (cfg_vco)
  );

  fb_divider u_fb (
    .vco_clk  (vco_clk),
    .rst_n    (rst_n),
    .w_i      (cfg_vco.w),
    .y_i      (cfg_vco.y),
    .fb_clk_o (fb_clk)
  );

  out_divider u_out (
    .vco_clk   (vco_clk),
    .rst_n     (rst_n),
    .x_i       (cfg_vco.x),
    .sys_clk_o (sys_clk)
  );

  assign rd_data  = word_from_cfg(cfg_ref, lock_w);
  assign slock    = lock_w;
  assign rst_hold = hold_w;
endmodule

// File: rtl/pll_divider_ctl_chk.sv
module pll_divider_ctl_chk (
  input logic        ref_clk,
  input logic        rst_n,
  input logic        wr_en,
  input logic [15:0] wr_data,
  input logic [15:0] rd_data,
  input logic        slock,
  input logic        rst_hold
);
  logic loop_diff;
  assign loop_diff = ({wr_data[15], wr_data[13:8]} != {rd_data[15], rd_data[13:8]});

  AST_LOOP_WRITE_DROPS_LOCK: assert property (@(posedge ref_clk) disable iff (!rst_n)
    (wr_en && loop_diff) |=> !slock); // R5

  AST_OUTSIDE_WRITE_KEEPS_LOCK: assert property (@(posedge ref_clk) disable iff (!rst_n)
    (wr_en && !loop_diff && slock) |=> slock); // R6

  AST_LOCK_STICKY: assert property (@(posedge ref_clk) disable iff (!rst_n)
    (!wr_en && slock) |=> slock); // R5

  AST_HOLD_FALLS_WITH_LOCK: assert property (@(posedge ref_clk) disable iff (!rst_n)
    $fell(rst_hold) |-> slock); // R8

  AST_HOLD_NEVER_RETURNS: assert property (@(posedge ref_clk) disable iff (!rst_n)
    !rst_hold |=> !rst_hold); // R8

  AST_UNUSED_BITS_ZERO: assert property (@(posedge ref_clk) disable iff (!rst_n)
    ((rd_data & 16'h00F7) == 16'h0000) && (rd_data[3] == slock)); // R1
endmodule

bind pll_divider_ctl pll_divider_ctl_chk u_chk (
  .ref_clk  (ref_clk),
  .rst_n    (rst_n),
  .wr_en    (wr_en),
  .wr_data  (wr_data),
  .rd_data  (rd_data),
  .slock    (slock),
  .rst_hold (rst_hold)
);

// File: tb/test_pll_divider_ctl.sv
`timescale 1ns/1ps
module test_pll_divider_ctl;
  localparam int L = 12;

  logic        ref_clk = 1'b0;
  logic        vco_clk = 1'b0;
  logic        rst_n   = 1'b0;
  logic        wr_en   = 1'b0;
  logic [15:0] wr_data = '0;
  logic [15:0] rd_data;
  logic        sys_clk, fb_clk, slock, rst_hold;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  always #10 ref_clk = ~ref_clk;  // 50 MHz
  always #1  vco_clk = ~vco_clk;

  pll_divider_ctl #(.RELOCK_CYCLES(L)) i_pll_divider_ctl (
    .ref_clk(ref_clk), .vco_clk(vco_clk), .rst_n(rst_n), .wr_en(wr_en),
    .wr_data(wr_data), .rd_data(rd_data), .sys_clk(sys_clk), .fb_clk(fb_clk),
    .slock(slock), .rst_hold(rst_hold)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic reg_write(input logic [15:0] d);
    @(negedge ref_clk);
    wr_data = d;
    wr_en   = 1'b1;
    @(negedge ref_clk);
    wr_en   = 1'b0;
  endtask

  task automatic wait_neg(input int n);
    repeat (n) @(negedge ref_clk);
  endtask

  // lock flag must still be low after L-1 edges and high after L (R5)
  task automatic check_relock(input string req);
    wait_neg(L - 1);
    check(slock == 1'b0, req, slock, 0);
    wait_neg(1);
    check(slock == 1'b1, req, slock, 1);
  endtask

  task automatic meas(input bit use_fb, output longint per);
    longint t0;
    if (use_fb) begin
      @(posedge fb_clk); @(posedge fb_clk); t0 = $time; @(posedge fb_clk);
    end else begin
      @(posedge sys_clk); @(posedge sys_clk); t0 = $time; @(posedge sys_clk);
    end
    per = $time - t0;
  endtask

  // R10 monitor: every sys_clk pulse lasts 1 or 2 oscillator cycles (2 or 4 ns)
  longint last_t   = 0;
  bit     have_t   = 0;
  int     bad_w    = 0;
  longint bad_val  = 0;
  longint pw       = 0;
  always @(sys_clk) begin
    if (rst_n) begin
      if (have_t) begin
        pw = $time - last_t;
        if (!(pw == 2 || pw == 4)) begin
          bad_w++;
          bad_val = pw;
        end
      end
      have_t = 1;
      last_t = $time;
    end else begin
      have_t = 0;
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #3_000_000;
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  initial begin
    longint per;
    longint exp_per;
    logic [15:0] d;
    int ys[8] = '{0, 1, 2, 5, 15, 31, 62, 63};

    #16;
    check(rd_data == 16'h3F00, "R2 reset value", rd_data, 16'h3F00);
    check(slock == 1'b0, "R2 reset lock", slock, 0);
    check(rst_hold == 1'b1, "R2 reset hold", rst_hold, 1);
    #40 rst_n = 1'b1;  // t=56, clear of all edges
    @(negedge ref_clk);

    // first lock after reset, with the reset hold
    wait_neg(L - 1);
    check(slock == 1'b0, "R8 lock before count", slock, 0);
    check(rst_hold == 1'b1, "R8 hold before lock", rst_hold, 1);
    wait_neg(1);
    check(slock == 1'b1, "R8 lock reached", slock, 1);
    check(rst_hold == 1'b0, "R8 hold released", rst_hold, 0);

    // default ratio at reset: W=0, Y=63, X=0
    meas(1'b1, per);
    check(per == 2048, "R3 reset fb period", per, 2048);
    meas(1'b0, per);
    check(per == 8, "R4 reset sys period", per, 8);

    // X-only write while locked
    reg_write(16'h7F00);
    check(slock == 1'b1, "R6 x-only write", slock, 1);
    wait_neg(3);
    check(slock == 1'b1, "R6 x-only later", slock, 1);
    check(rd_data == 16'h7F08, "R1 readback with lock", rd_data, 16'h7F08);
    meas(1'b0, per);
    check(per == 4, "R4 x=1 period", per, 4);

    // unused bits, W/Y change drops lock, hold stays released
    reg_write(16'hFFFF);
    check(rd_data == 16'hFF00, "R1 unused bits zero", rd_data, 16'hFF00);
    check(slock == 1'b0, "R5 lock dropped", slock, 0);
    check(rst_hold == 1'b0, "R8 hold stays low", rst_hold, 0);

    // writing bit 3 during relock does not set lock
    reg_write(16'hFF08);
    check(slock == 1'b0, "R7 lock bit write", slock, 0);
    check(rd_data[3] == 1'b0, "R7 readback bit3", rd_data[3], 0);

    // restart by a second loop write while unlocked
    reg_write(16'h8100);
    wait_neg(5);
    reg_write(16'h8300);
    check_relock("R9 restarted relock");

    // sweep W, Y and X
    for (int w = 0; w < 2; w++) begin
      for (int k = 0; k < 8; k++) begin
        d = {w[0], ys[k][0] ^ w[0], ys[k][5:0], 8'h00};
        reg_write(d);
        check(slock == 1'b0, "R5 sweep drop", slock, 0);
        check_relock("R5 sweep relock");
        check(rd_data == (d | 16'h0008), "R1 sweep readback", rd_data, d | 16'h0008);
        meas(1'b1, per);
        exp_per = 2 * 16 * (ys[k] + 1) * ((w == 1) ? 4 : 1);
        check(per == exp_per, "R3 fb period", per, exp_per);
        meas(1'b0, per);
        exp_per = d[14] ? 4 : 8;
        check(per == exp_per, "R4 sys period", per, exp_per);
      end
    end

    // rapid X toggles, lock undisturbed, pulses never cut short
    for (int i = 0; i < 12; i++) begin
      d = {rd_data[15], i[0], rd_data[13:8], 8'h00};
      reg_write(d);
      check(slock == 1'b1, "R6 x toggle lock", slock, 1);
      #(2 * (i + 1));
    end
    wait_neg(4);
    check(bad_w == 0, "R10 pulse width", bad_val, 4);

    finish_run();
  end
endmodule